// File: doc/BRIEF.md
# Tone-Pair Symbol Status Sequencer

This block is the control and status end of a tone-pair (touch-tone) receiver. A signal-processing front end, outside this block, reports on every sample tick whether signal energy is present, whether the dual-tone criteria pass, and which of the sixteen digits it decoded. The sequencer walks one symbol through four stages: early detect, dual tone confirmed, on-time satisfied, and symbol detected. Each stage has its own status flag and its own way back to searching when its test fails. The host reads the result from an 8-bit status byte. A 4-bit copy of the flags, one clock behind, feeds an interrupt aggregator.

All timing is counted in sample ticks. The early-detect and dual-tone delays are fixed tick counts set by parameters. The on-time, off-time and cycle-time thresholds are 16-bit inputs that the host programs. Cycle time runs from the first energy tick to the tick that completes the off-time gap. The host clears flags with a write-to-clear strobe. Clearing an intermediate flag in the middle of a detection aborts that detection. The thresholds are unaffected. The sequencer runs only under a fixed set of configuration codes.

The interfaces are plain control and status pins. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `dtmf_status_seq`

## Requirements
- R1: Status byte layout: bit 7 early detect, bit 6 dual tone confirmed, bit 5 on-time satisfied, bit 4 symbol detected, bits 3:0 latched digit. The copy nibble carries the same four flags in the same order (bit 3 early ... bit 0 symbol). Reset clears both to zero.
- R2: Energy is counted from the first tick on which it is present (tick 1). Early detect sets on the tick where that count reaches EARLY_TICKS (at least 2). If energy drops before then, searching resumes with no flag set.
- R3: Dual tone confirmed sets on tick EARLY_TICKS+DUAL_TICKS of the tone, provided energy and the dual-tone pass flag are both high on that tick. The input digit is latched into bits 3:0 on that same tick, and only on that tick.
- R4: If the pass flag is low on that tick, or energy drops while early detect is set, early detect clears and searching resumes. The digit field is unchanged.
- R5: Once dual tone is confirmed, on-time satisfied sets on the first tick with energy where the tone count is at least the on-time threshold. If energy drops first, early detect and dual tone clear and searching resumes.
- R6: After on-time is satisfied, a gap counter counts ticks without energy. When the gap count reaches the off-time threshold, early, dual and on-time flags clear. Symbol detected then sets if the tone count (including gap ticks) has reached the cycle-time threshold. Energy returning during the gap clears those three flags without setting symbol detected.
- R7: A host write-to-clear with bit 6 set while dual tone is confirmed and on-time is not yet satisfied returns the sequencer to searching and clears the upper three flags.
- R8: A host write-to-clear with bit 5 set while on-time is satisfied and the symbol is not yet detected does the same.
- R9: Writing bit 4 clears symbol detected, which otherwise holds. If a new symbol completes on the same tick, setting wins. Writes to bit 7 have no effect.
- R10: The copy nibble equals the four flags as they stood one clock earlier, so clearing a flag reaches the copy on the next clock.
- R11: The sequencer runs only under configuration codes 21h, 90h, 98h, 92h, 94h, 82h and 86h. Under any other code all four flags are held at zero from the next clock.
- R12: Stage progress and flag setting happen only on clocks where the tick input is high. Host clears act on any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock sample tick |
| energy | input | 1 | Signal energy present this sample |
| dual_ok | input | 1 | Dual-tone criteria pass this sample |
| digit_in | input | 4 | Decoded digit from the front end |
| on_time | input | THR_W | Minimum tone ticks |
| off_time | input | THR_W | Required gap ticks |
| cycle_time | input | THR_W | Minimum ticks from tone start to gap end |
| cfg_code | input | 8 | Configuration code |
| clr_en | input | 1 | Host write-to-clear strobe |
| clr_data | input | 8 | Write data; a 1 in bits 6..4 clears that flag |
| status | output | 8 | Status byte |
| flag_copy | output | 4 | Delayed copy of the four flags |

## Verification
Every flag change caused by a tick or a host clear shows on `status` after the clock edge that samples that input. The copy nibble follows one clock later, and leaving the enabled code set zeroes the flags one clock after the code changes. The bench drives inputs and compares outputs on the falling edge, half a cycle away from any active edge. A behavioural model advances on each rising edge and is compared on every falling edge. Directed checks are timed by counting the ticks applied since each tone began, so every stage boundary is probed just before and just after the tick on which it is due.

// File: rtl/dtmf_pkg.sv
`timescale 1ns/1ps
package dtmf_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_ARM,
    ST_EARLY,
    ST_TONE,
    ST_GAP
  } stage_t;

  typedef struct packed {
    logic early;
    logic dual;
    logic ontime;
    logic found;
  } flags_t;

  localparam int NUM_CODES = 7;
  localparam logic [NUM_CODES*8-1:0] RUN_CODES =
    {8'h21, 8'h90, 8'h98, 8'h92, 8'h94, 8'h82, 8'h86};

endpackage

// File: rtl/dtmf_mode_gate.sv
`timescale 1ns/1ps
module dtmf_mode_gate
  import dtmf_pkg::*;
(
  input  logic [7:0] cfg_code,
  output logic       run
);

  logic [NUM_CODES-1:0] hit;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign hit[i] = (cfg_code == RUN_CODES[i*8 +: 8]);
  end

  assign run = |hit;

endmodule

// File: rtl/dtmf_stage_ctrl.sv
`timescale 1ns/1ps
module dtmf_stage_ctrl
  import dtmf_pkg::*;
#(
  parameter int EARLY_TICKS = 160,
  parameter int DUAL_TICKS  = 88,
  parameter int THR_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             energy,
  input  logic             dual_ok,
  input  logic [3:0]       digit_in,
  input  logic [THR_W-1:0] on_time,
  input  logic [THR_W-1:0] off_time,
  input  logic [THR_W-1:0] cycle_time,
  input  logic             abort,
  input  logic             found_clr,
  output flags_t           flags,
  output logic [3:0]       digit_q
);

  localparam int AW = THR_W + 1;
  localparam logic [AW-1:0] EARLY_AT = AW'(EARLY_TICKS);
  localparam logic [AW-1:0] DUAL_AT  = AW'(EARLY_TICKS + DUAL_TICKS);
  localparam logic [AW-1:0] CNT_MAX  = '1;

  stage_t        stage_q;
  flags_t        flags_q;
  logic [AW-1:0] age_q, gap_q, age_inc, gap_inc;

  assign age_inc = (age_q == CNT_MAX) ? age_q : age_q + 1'b1;
  assign gap_inc = (gap_q == CNT_MAX) ? gap_q : gap_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_SEARCH;
      flags_q <= '0;
      age_q   <= '0;
      gap_q   <= '0;
      digit_q <= '0;
    end else if (!run) begin
      stage_q <= ST_SEARCH;
      flags_q <= '0;
      age_q   <= '0;
      gap_q   <= '0;
    end else begin
      if (found_clr) flags_q.found <= 1'b0;
      if (abort) begin
        stage_q        <= ST_SEARCH;
        flags_q.early  <= 1'b0;
        flags_q.dual   <= 1'b0;
        flags_q.ontime <= 1'b0;
        age_q          <= '0;
        gap_q          <= '0;
      end else if (tick) begin
        unique case (stage_q)
          ST_SEARCH: begin
            if (energy) begin
              age_q   <= AW'(1);
              gap_q   <= '0;
              stage_q <= ST_ARM;
            end
          end
          ST_ARM: begin
            if (!energy) begin
              stage_q <= ST_SEARCH;
            end else begin
              age_q <= age_inc;
              if (age_inc == EARLY_AT) begin
                flags_q.early <= 1'b1;
                stage_q       <= ST_EARLY;
              end
            end
          end
          ST_EARLY: begin
            if (!energy || (age_inc == DUAL_AT && !dual_ok)) begin
              flags_q.early <= 1'b0;
              stage_q       <= ST_SEARCH;
            end else begin
              age_q <= age_inc;
              if (age_inc == DUAL_AT) begin
                flags_q.dual <= 1'b1;
                digit_q      <= digit_in;
                stage_q      <= ST_TONE;
              end
            end
          end
          ST_TONE: begin
            if (!energy) begin
              flags_q.early <= 1'b0;
              flags_q.dual  <= 1'b0;
              stage_q       <= ST_SEARCH;
            end else begin
              age_q <= age_inc;
              if (age_inc >= {1'b0, on_time}) begin
                flags_q.ontime <= 1'b1;
                stage_q        <= ST_GAP;
              end
            end
          end
          ST_GAP: begin
            age_q <= age_inc;
            if (energy) begin
              if (gap_q != '0) begin
                flags_q.early  <= 1'b0;
                flags_q.dual   <= 1'b0;
                flags_q.ontime <= 1'b0;
                stage_q        <= ST_SEARCH;
              end
            end else begin
              gap_q <= gap_inc;
              if (gap_inc >= {1'b0, off_time}) begin
                if (age_inc >= {1'b0, cycle_time}) flags_q.found <= 1'b1;
                flags_q.early  <= 1'b0;
                flags_q.dual   <= 1'b0;
                flags_q.ontime <= 1'b0;
                stage_q        <= ST_SEARCH;
              end
            end
          end
          default: stage_q <= ST_SEARCH;
        endcase
      end
    end
  end

  assign flags = flags_q;

  // R12
  early_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.early) |-> $past(tick));
  // R3
  dual_after_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.dual) |-> $past(flags_q.early));
  // R5
  ontime_after_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.ontime) |-> flags_q.dual);
  // R6
  found_clears_stages_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.found) |-> !flags_q.early && !flags_q.dual && !flags_q.ontime);

endmodule

// File: rtl/dtmf_flag_mirror.sv
`timescale 1ns/1ps
module dtmf_flag_mirror
  import dtmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  flags_t     flags,
  output logic [3:0] copy_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) copy_q <= '0;
    else        copy_q <= flags;
  end

  // R10
  copy_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_q == $past(flags));

endmodule

// File: rtl/dtmf_status_seq.sv
`timescale 1ns/1ps
module dtmf_status_seq
  import dtmf_pkg::*;
#(
  parameter int EARLY_TICKS = 160,
  parameter int DUAL_TICKS  = 88,
  parameter int THR_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             energy,
  input  logic             dual_ok,
  input  logic [3:0]       digit_in,
  input  logic [THR_W-1:0] on_time,
  input  logic [THR_W-1:0] off_time,
  input  logic [THR_W-1:0] cycle_time,
  input  logic [7:0]       cfg_code,
  input  logic             clr_en,
  input  logic [7:0]       clr_data,
  output logic [7:0]       status,
  output logic [3:0]       flag_copy
);

  logic       run, abort, found_clr;
  flags_t     flags;
  logic [3:0] digit_q;

  dtmf_mode_gate u_gate (
    .cfg_code (cfg_code),
    .run      (run)
  );

  assign abort = clr_en && ((clr_data[6] && flags.dual) || (clr_data[5] && flags.ontime));
  assign found_clr = clr_en && clr_data[4];

  dtmf_stage_ctrl #(
    .EARLY_TICKS (EARLY_TICKS),
    .DUAL_TICKS  (DUAL_TICKS),
    .THR_W       (THR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .energy     (energy),
    .dual_ok    (dual_ok),
    .digit_in   (digit_in),
    .on_time    (on_time),
    .off_time   (off_time),
    .cycle_time (cycle_time),
    .abort      (abort),
    .found_clr  (found_clr),
    .flags      (flags),
    .digit_q    (digit_q)
  );

  dtmf_flag_mirror u_mirror (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags  (flags),
    .copy_q (flag_copy)
  );

  assign status = {flags, digit_q};

  // R11
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> status[7:4] == 4'h0);
  // R7
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && abort |=> status[7:5] == 3'b000);

endmodule

// File: tb/sim_dtmf_status_seq.sv
`timescale 1ns/1ps
module sim_dtmf_status_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1, energy = 1'b0, dual_ok = 1'b0, clr_en = 1'b0;
  logic [3:0]  digit_in = 4'h0;
  logic [15:0] on_time = 16'd300, off_time = 16'd40, cycle_time = 16'd380;
  logic [7:0]  cfg_code = 8'h21, clr_data = 8'h00;
  logic [7:0]  status;
  logic [3:0]  flag_copy;

  int checks = 0, fails = 0, cyc = 0, phase = 0, tick_div = 1;

  always #2.5 clk = ~clk;

  dtmf_status_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .energy(energy), .dual_ok(dual_ok),
    .digit_in(digit_in), .on_time(on_time), .off_time(off_time),
    .cycle_time(cycle_time), .cfg_code(cfg_code), .clr_en(clr_en),
    .clr_data(clr_data), .status(status), .flag_copy(flag_copy)
  );

  // Behavioural reference model
  int   m_stage = 0, m_age = 0, m_gap = 0;
  bit   me, md, mo, mf;
  logic [3:0] m_dig = 4'h0, m_copy = 4'h0;

  function automatic bit code_runs(logic [7:0] c);
    return c inside {8'h21, 8'h90, 8'h98, 8'h92, 8'h94, 8'h82, 8'h86};
  endfunction

  always @(posedge clk) begin
    bit kill;
    m_copy = {me, md, mo, mf};
    if (!rst_n) begin
      m_stage = 0; m_age = 0; m_gap = 0; me = 0; md = 0; mo = 0; mf = 0; m_dig = 0;
    end else if (!code_runs(cfg_code)) begin
      m_stage = 0; m_age = 0; m_gap = 0; me = 0; md = 0; mo = 0; mf = 0;
    end else begin
      kill = clr_en && ((clr_data[6] && md) || (clr_data[5] && mo));
      if (clr_en && clr_data[4]) mf = 0;
      if (kill) begin
        m_stage = 0; m_age = 0; m_gap = 0; me = 0; md = 0; mo = 0;
      end else if (tick) begin
        if (m_stage == 0) begin
          if (energy) begin m_age = 1; m_gap = 0; m_stage = 1; end
        end else if (m_stage == 1) begin
          if (!energy) m_stage = 0;
          else begin
            m_age++;
            if (m_age == 160) begin me = 1; m_stage = 2; end
          end
        end else if (m_stage == 2) begin
          if (!energy || (m_age + 1 == 248 && !dual_ok)) begin me = 0; m_stage = 0; end
          else begin
            m_age++;
            if (m_age == 248) begin md = 1; m_dig = digit_in; m_stage = 3; end
          end
        end else if (m_stage == 3) begin
          if (!energy) begin me = 0; md = 0; m_stage = 0; end
          else begin
            m_age++;
            if (m_age >= int'(on_time)) begin mo = 1; m_stage = 4; end
          end
        end else begin
          m_age++;
          if (energy) begin
            if (m_gap != 0) begin me = 0; md = 0; mo = 0; m_stage = 0; end
          end else begin
            m_gap++;
            if (m_gap >= int'(off_time)) begin
              if (m_age >= int'(cycle_time)) mf = 1;
              me = 0; md = 0; mo = 0; m_stage = 0;
            end
          end
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // every-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    chk({4'h0, status[7:4]}, {4'h0, me, md, mo, mf}, "R2/R3/R5/R6 flags vs model");
    chk({4'h0, status[3:0]}, {4'h0, m_dig}, "R3 digit vs model");
    chk({4'h0, flag_copy}, {4'h0, m_copy}, "R10 copy vs model");
  end

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_report();
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      phase++;
      tick = ((phase % tick_div) == 0);
    end
  endtask

  task automatic host_clear(input logic [7:0] d);
    clr_en = 1'b1; clr_data = d;
    step();
    clr_en = 1'b0; clr_data = 8'h00;
  endtask

  task automatic tone(input logic [3:0] d, input int on_n, input int off_n);
    digit_in = d; dual_ok = 1'b1; energy = 1'b1;
    step(on_n);
    energy = 1'b0;
    step(off_n);
  endtask

  initial begin
    step(5);
    chk(status, 8'h00, "R1 reset status");
    chk({4'h0, flag_copy}, 8'h00, "R1 reset copy");
    rst_n = 1'b1;

    // full symbol, set beating a simultaneous clear
    digit_in = 4'h5; dual_ok = 1'b1; energy = 1'b1;
    step(200); chk({4'h0, status[7:4]}, 8'h08, "R2 early only");
    step(60);  chk(status, 8'hC5, "R3 dual and digit");
    step(60);  chk({4'h0, status[7:4]}, 8'h0E, "R5 on-time");
    step(30);  energy = 1'b0;
    step(39);  host_clear(8'h10);
    chk({7'h0, status[4]}, 8'h01, "R9 set wins over clear");
    chk({5'h0, status[7:5]}, 8'h00, "R6 stages cleared on symbol");
    step();    chk({4'h0, flag_copy}, 8'h01, "R10 copy shows symbol");
    step(20);

    // bit 7 write ignored, symbol clear and copy lag
    digit_in = 4'h9; energy = 1'b1;
    step(200); host_clear(8'h80);
    chk({7'h0, status[7]}, 8'h01, "R9 early unaffected by write");
    host_clear(8'h10);
    chk({7'h0, status[4]}, 8'h00, "R9 symbol cleared");
    chk({7'h0, flag_copy[0]}, 8'h01, "R10 copy still old");
    step();    chk({7'h0, flag_copy[0]}, 8'h00, "R10 copy cleared one clock later");
    step(145); energy = 1'b0; step(60);

    // dual-tone failure
    digit_in = 4'h3; dual_ok = 1'b0; energy = 1'b1;
    step(260); chk({6'h0, status[7:6]}, 8'h00, "R4 early retreat");
    chk({4'h0, status[3:0]}, 8'h09, "R4 digit kept");
    step(90);  energy = 1'b0; step(60);

    // on-time failure
    digit_in = 4'h7; dual_ok = 1'b1; energy = 1'b1;
    step(280); chk({5'h0, status[7:5]}, 8'h06, "R5 before tone end");
    energy = 1'b0; step();
    chk({5'h0, status[7:5]}, 8'h00, "R5 retreat on short tone");
    step(60);

    // gap broken early
    host_clear(8'h10);
    digit_in = 4'h2; energy = 1'b1; step(350);
    energy = 1'b0; step(20);
    energy = 1'b1; step();
    chk({4'h0, status[7:4]}, 8'h00, "R6 gap broken");
    energy = 1'b0; step(60);

    // cycle time not met
    cycle_time = 16'd500;
    tone(4'h1, 350, 60);
    chk({7'h0, status[4]}, 8'h00, "R6 cycle too short");
    cycle_time = 16'd380;

    // host aborts
    energy = 1'b1; step(260); host_clear(8'h40);
    chk({5'h0, status[7:5]}, 8'h00, "R7 abort from dual stage");
    step(100); chk({5'h0, status[7:5]}, 8'h00, "R7 restarted search");
    energy = 1'b0; step(40);
    energy = 1'b1; step(320); host_clear(8'h20);
    chk({5'h0, status[7:5]}, 8'h00, "R8 abort from on-time stage");
    energy = 1'b0; step(40);

    // tick gating
    tick_div = 2; energy = 1'b1;
    step(300); chk({7'h0, status[7]}, 8'h00, "R12 half-rate ticks not yet");
    step(40);  chk({7'h0, status[7]}, 8'h01, "R12 half-rate ticks early");
    energy = 1'b0; step(60); tick_div = 1; step();

    // mode gating
    tone(4'h4, 350, 60);
    chk({7'h0, status[4]}, 8'h01, "R11 symbol under code 21h");
    cfg_code = 8'h00; step();
    chk({4'h0, status[7:4]}, 8'h00, "R11 flags zero when off");
    digit_in = 4'h6; energy = 1'b1; step(260);
    chk({4'h0, status[7:4]}, 8'h00, "R11 idle under code 00h");
    energy = 1'b0; step(60);
    cfg_code = 8'h86; tone(4'hA, 350, 60);
    chk(status, 8'h1A, "R11 symbol under code 86h");

    step(10);
    finish_report();
  end

endmodule